// File: doc/BRIEF.md
# SPI Slave with Command-Byte Tagging

This block is a four-wire SPI slave that sits behind an external SPI master. It shifts bytes in on MOSI and out on MISO, and hands the received bytes to on-chip logic as a stream of single-cycle strobes. The first byte of every transaction (the span during which the active-low select is held low) carries a flag marking it as the command byte. Every later byte in the same transaction is a data byte. What the command means is left to the logic downstream.

All serial inputs are brought into the system clock domain through synchronisers, and every clock edge is found by edge detection. The clock polarity, the clock phase and the bit order are runtime inputs, so all four SPI modes work with either MSB-first or LSB-first words. Bytes to send are loaded through a one-entry holding register. When the slot for a byte begins and no byte is waiting, the slave shifts out zero. If the master raises the select in the middle of a byte, the slave drops the partial byte and returns to idle. On the system side the start and the end of each transaction are reported as pulses.

Top module: `spi_cmd_slave`

## Requirements
- R1: `xfer_start` pulses for one cycle when a falling edge of `spi_ss_n` is seen, and `xfer_end` pulses for one cycle when a rising edge is seen, exactly once per transaction.
- R2: The first byte reported in a transaction has `rx_is_cmd` = 1. Every later byte in that transaction has `rx_is_cmd` = 0.
- R3: The mode inputs are applied as mode = {`cfg_cpol`, `cfg_cpha`}, and the idle SCLK level is `cfg_cpol`. When CPOL equals CPHA, MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge. Otherwise MOSI is sampled on the falling edge and MISO changes on the rising edge. Bytes are exchanged correctly in all four modes.
- R4: With `cfg_lsb_first` = 1, bit 0 of each byte travels first in both directions. With `cfg_lsb_first` = 0, bit 7 travels first.
- R5: With CPHA = 0, the first bit of the byte being sent is on MISO after the select falls and before the first SCLK edge.
- R6: When the select rises before 8 bits have been sampled, the partial byte is never reported. The next transaction begins at bit 0 with a command byte.
- R7: While `spi_ss_n` is high, `spi_miso` is 0.
- R8: When a byte slot starts with no byte loaded, the slave sends 0x00 in that slot.
- R9: `rx_valid` is a single-cycle pulse, and `rx_is_cmd` is only ever 1 while `rx_valid` is 1.
- R10: SCLK and MOSI activity while `spi_ss_n` is high produces no received byte and leaves MISO low.
- R11: A byte loaded with `tx_load` is sent in the next byte slot that starts after the load. This holds even when the load happens while an earlier byte is still shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Clock polarity (idle SCLK level) |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not selected |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_is_cmd | output | 1 | Marks the received byte as the command byte |
| tx_load | input | 1 | Load strobe for the next byte to send |
| tx_data | input | 8 | Byte to send |
| xfer_start | output | 1 | One-cycle pulse at the start of a transaction |
| xfer_end | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
The hardest case to produce from the ports is an abort in the middle of a byte, followed by a clean restart. Getting it requires the select to rise while the bit counters are non-zero, and the damage shows only in the next transaction. The bench sends half a byte in mode 0 and raises the select. It then runs a full transaction and checks that no byte was reported for the aborted part and that the new first byte arrives intact with the command flag set. The phase-dependent byte slot is the second hard case. For CPHA = 0 the next slot opens on the trailing edge of the previous byte's last bit. The bench therefore loads the following byte partway through the current byte in every mode and bit order, and leaves some slots unloaded so that zero is sent.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    localparam int unsigned SPI_W     = 8;
    localparam int unsigned SPI_CNT_W = $clog2(SPI_W);

    typedef struct packed {
        logic                 active;
        logic                 first;
        logic [SPI_CNT_W-1:0] rx_cnt;
        logic [SPI_CNT_W-1:0] tx_cnt;
        logic [SPI_W-1:0]     rx_sh;
        logic [SPI_W-1:0]     tx_sh;
        logic [SPI_W-1:0]     tx_hold;
        logic                 tx_pend;
        logic                 miso;
        logic                 rx_valid;
        logic [SPI_W-1:0]     rx_data;
        logic                 rx_cmd;
        logic                 start;
        logic                 stop;
    } spi_eng_t;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int unsigned   N       = 3,
    parameter int unsigned   STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    localparam int unsigned CHAIN = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {CHAIN{RST_VAL[g]}};
            else        chain_q <= {chain_q[CHAIN-2:0], din[g]};
        end

        assign dout[g] = chain_q[STAGES-1];
        assign rise[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[g] = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
    import spi_slv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             sel_on,
    input  logic             sel_off,
    input  logic             mosi_bit,
    input  logic             tx_load,
    input  logic [SPI_W-1:0] tx_data,
    output logic             miso,
    output logic             rx_valid,
    output logic [SPI_W-1:0] rx_data,
    output logic             rx_is_cmd,
    output logic             xfer_start,
    output logic             xfer_end
);

    localparam logic [SPI_CNT_W-1:0] LAST_BIT = SPI_CNT_W'(SPI_W - 1);

    spi_eng_t st_q, st_d;

    logic             cap_on_rise;
    logic             capture;
    logic             launch;
    logic [SPI_W-1:0] next_byte;
    logic [SPI_W-1:0] rx_asm;

    always_comb begin
        cap_on_rise = (cpol == cpha);
        capture     = cap_on_rise ? sclk_rise : sclk_fall;
        launch      = cap_on_rise ? sclk_fall : sclk_rise;
        next_byte   = st_q.tx_pend ? st_q.tx_hold : '0;
        rx_asm      = lsb_first ? {mosi_bit, st_q.rx_sh[SPI_W-1:1]}
                                : {st_q.rx_sh[SPI_W-2:0], mosi_bit};

        st_d          = st_q;
        st_d.rx_valid = 1'b0;
        st_d.rx_cmd   = 1'b0;
        st_d.start    = 1'b0;
        st_d.stop     = 1'b0;

        if (sel_on) begin
            st_d.active = 1'b1;
            st_d.first  = 1'b1;
            st_d.rx_cnt = '0;
            st_d.tx_cnt = '0;
            st_d.rx_sh  = '0;
            st_d.start  = 1'b1;
            st_d.tx_sh  = '0;
            if (!cpha) begin
                st_d.tx_sh   = next_byte;
                st_d.tx_pend = 1'b0;
                st_d.tx_cnt  = SPI_CNT_W'(1);
            end
        end else if (sel_off) begin
            st_d.active = 1'b0;
            st_d.rx_cnt = '0;
            st_d.tx_cnt = '0;
            st_d.rx_sh  = '0;
            st_d.tx_sh  = '0;
            st_d.stop   = st_q.active;
        end else if (st_q.active) begin
            if (capture) begin
                st_d.rx_sh = rx_asm;
                if (st_q.rx_cnt == LAST_BIT) begin
                    st_d.rx_valid = 1'b1;
                    st_d.rx_data  = rx_asm;
                    st_d.rx_cmd   = st_q.first;
                    st_d.first    = 1'b0;
                    st_d.rx_cnt   = '0;
                end else begin
                    st_d.rx_cnt = st_q.rx_cnt + 1'b1;
                end
            end
            if (launch) begin
                if (st_q.tx_cnt == '0) begin
                    st_d.tx_sh   = next_byte;
                    st_d.tx_pend = 1'b0;
                end else if (lsb_first) begin
                    st_d.tx_sh = st_q.tx_sh >> 1;
                end else begin
                    st_d.tx_sh = st_q.tx_sh << 1;
                end
                st_d.tx_cnt = (st_q.tx_cnt == LAST_BIT) ? '0 : st_q.tx_cnt + 1'b1;
            end
        end

        if (tx_load) begin
            st_d.tx_hold = tx_data;
            st_d.tx_pend = 1'b1;
        end

        st_d.miso = st_d.active &
                    (lsb_first ? st_d.tx_sh[0] : st_d.tx_sh[SPI_W-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso       = st_q.miso;
    assign rx_valid   = st_q.rx_valid;
    assign rx_data    = st_q.rx_data;
    assign rx_is_cmd  = st_q.rx_cmd;
    assign xfer_start = st_q.start;
    assign xfer_end   = st_q.stop;

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spi_slv_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             spi_sclk,
    input  logic             spi_ss_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             rx_valid,
    output logic [SPI_W-1:0] rx_data,
    output logic             rx_is_cmd,
    input  logic             tx_load,
    input  logic [SPI_W-1:0] tx_data,
    output logic             xfer_start,
    output logic             xfer_end
);

    localparam int unsigned IDX_SCLK = 0;
    localparam int unsigned IDX_SEL  = 1;
    localparam int unsigned IDX_MOSI = 2;

    logic [2:0] raw_in;
    logic [2:0] sync_lvl;
    logic [2:0] sync_rise;
    logic [2:0] sync_fall;

    assign raw_in = {spi_mosi, spi_ss_n, spi_sclk};

    spi_slv_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_lvl),
        .rise  (sync_rise),
        .fall  (sync_fall)
    );

    spi_slv_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (cfg_cpol),
        .cpha       (cfg_cpha),
        .lsb_first  (cfg_lsb_first),
        .sclk_rise  (sync_rise[IDX_SCLK]),
        .sclk_fall  (sync_fall[IDX_SCLK]),
        .sel_on     (sync_fall[IDX_SEL]),
        .sel_off    (sync_rise[IDX_SEL]),
        .mosi_bit   (sync_lvl[IDX_MOSI]),
        .tx_load    (tx_load),
        .tx_data    (tx_data),
        .miso       (spi_miso),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_is_cmd  (rx_is_cmd),
        .xfer_start (xfer_start),
        .xfer_end   (xfer_end)
    );

endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_ss_n,
    input logic spi_miso,
    input logic rx_valid,
    input logic rx_is_cmd,
    input logic xfer_start,
    input logic xfer_end
);

    logic in_xfer_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_xfer_q <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            if (xfer_start)    in_xfer_q <= 1'b1;
            else if (xfer_end) in_xfer_q <= 1'b0;
            if (xfer_start)    seen_q <= 1'b0;
            else if (rx_valid) seen_q <= 1'b1;
        end
    end

    p_pulses_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || xfer_end) |=> !(xfer_start || xfer_end));

    p_cmd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_is_cmd == !seen_q));

    p_no_partial_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> in_xfer_q);

    p_miso_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_ss_n && $past(spi_ss_n, 1) && $past(spi_ss_n, 2) && $past(spi_ss_n, 3))
        |-> !spi_miso);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_cmd_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_is_cmd |-> rx_valid);

endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_ss_n   (spi_ss_n),
    .spi_miso   (spi_miso),
    .rx_valid   (rx_valid),
    .rx_is_cmd  (rx_is_cmd),
    .xfer_start (xfer_start),
    .xfer_end   (xfer_end)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;

    localparam int HALF = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic       spi_sclk = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic       rx_valid, rx_is_cmd, xfer_start, xfer_end;
    logic [7:0] rx_data;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;

    always #2.5 clk = ~clk;

    spi_cmd_slave dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_lsb_first(lsb), .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_is_cmd(rx_is_cmd), .tx_load(tx_load),
        .tx_data(tx_data), .xfer_start(xfer_start), .xfer_end(xfer_end)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] rx_log [0:7];
    logic       cmd_log [0:7];
    int rx_n = 0, start_n = 0, end_n = 0;

    always @(negedge clk) begin
        if (rx_valid) begin
            if (rx_n < 8) begin
                rx_log[rx_n]  = rx_data;
                cmd_log[rx_n] = rx_is_cmd;
            end
            rx_n++;
        end
        if (xfer_start) start_n++;
        if (xfer_end)   end_n++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rx_n = 0; start_n = 0; end_n = 0;
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk); tx_load = 1'b1; tx_data = b;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] mo, input bit do_load,
                             input logic [7:0] nxt, output logic [7:0] mi);
        mi = '0;
        for (int i = 0; i < 8; i++) begin
            int b;
            b = lsb ? i : 7 - i;
            if (!cpha) begin
                spi_mosi = mo[b]; #HALF;
                spi_sclk = ~cpol; mi[b] = spi_miso; #HALF;
                spi_sclk = cpol;
            end else begin
                spi_sclk = ~cpol; spi_mosi = mo[b]; #HALF;
                spi_sclk = cpol; mi[b] = spi_miso; #HALF;
            end
            if (do_load && i == 3) load_tx(nxt);
        end
    endtask

    typedef struct packed {
        logic [1:0]  mode;
        logic        lsbf;
        logic [1:0]  nb;
        logic [23:0] mosi;
        logic [23:0] txb;
        logic [2:0]  txv;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 1'b0, 2'd1, 24'h0000A5, 24'h00003C, 3'b001},
        '{2'd1, 1'b0, 2'd2, 24'h003412, 24'h00C381, 3'b011},
        '{2'd2, 1'b0, 2'd3, 24'h5A0F96, 24'h7E1101, 3'b101},
        '{2'd3, 1'b0, 2'd2, 24'h00F001, 24'h0055AA, 3'b010},
        '{2'd0, 1'b1, 2'd2, 24'h00C80D, 24'h00B163, 3'b011},
        '{2'd1, 1'b1, 2'd1, 24'h000081, 24'h0000E7, 3'b001},
        '{2'd2, 1'b1, 2'd3, 24'hFF0077, 24'h246810, 3'b111},
        '{2'd3, 1'b1, 2'd3, 24'h01806C, 24'h9A0000, 3'b100}
    };

    task automatic run_vec(input vec_t v);
        logic [7:0] mi;
        logic [7:0] exp_tx;
        @(negedge clk);
        {cpol, cpha} = v.mode; lsb = v.lsbf; spi_sclk = v.mode[1];
        repeat (4) @(negedge clk);
        clear_logs();
        if (v.txv[0]) load_tx(v.txb[7:0]);
        spi_ss_n = 1'b0; #HALF;
        for (int k = 0; k < int'(v.nb); k++) begin
            bit nl;
            nl = (k + 1 < int'(v.nb)) && v.txv[k+1];
            xfer_byte(v.mosi[8*k +: 8], nl, v.txb[8*(k+1) +: 8], mi);
            exp_tx = v.txv[k] ? v.txb[8*k +: 8] : 8'h00;
            // R3 R4 R5 R8 R11: byte seen by master on MISO
            chk(mi === exp_tx, "R3/R4/R5/R8/R11 miso byte", mi, exp_tx);
        end
        #HALF; spi_ss_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(rx_n == int'(v.nb), "R9 rx strobe count", rx_n, v.nb);
        for (int k = 0; k < int'(v.nb) && k < rx_n; k++) begin
            chk(rx_log[k] === v.mosi[8*k +: 8], "R3/R4 rx byte", rx_log[k], v.mosi[8*k +: 8]);
            chk(cmd_log[k] === (k == 0), "R2 command flag", cmd_log[k], (k == 0));
        end
        chk(start_n == 1 && end_n == 1, "R1 start/end pulses", start_n*16 + end_n, 17);
        chk(spi_miso === 1'b0, "R7 miso idle", spi_miso, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // reset state
        chk(spi_miso === 1'b0 && rx_valid === 1'b0 && xfer_start === 1'b0,
            "R7 reset outputs", {spi_miso, rx_valid, xfer_start}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R10: bus activity with select high
        cpol = 0; cpha = 0; lsb = 0; spi_sclk = 0;
        clear_logs();
        for (int i = 0; i < 16; i++) begin
            spi_mosi = i[0]; #HALF; spi_sclk = ~spi_sclk;
            chk(spi_miso === 1'b0, "R10 miso low unselected", spi_miso, 0);
        end
        spi_sclk = 0;
        repeat (4) @(negedge clk);
        chk(rx_n == 0 && start_n == 0, "R10 no byte unselected", rx_n, 0);

        // R6: abort mid-byte, then clean restart
        clear_logs();
        spi_ss_n = 1'b0; #HALF;
        for (int i = 0; i < 4; i++) begin
            spi_mosi = 1'b1; #HALF; spi_sclk = 1'b1; #HALF; spi_sclk = 1'b0;
        end
        #HALF; spi_ss_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(rx_n == 0, "R6 partial byte dropped", rx_n, 0);
        chk(end_n == 1, "R1 end pulse on abort", end_n, 1);
        chk(spi_miso === 1'b0, "R7 miso after abort", spi_miso, 0);
        run_vec('{2'd0, 1'b0, 2'd2, 24'h00C33C, 24'h000000, 3'b000});
        chk(rx_n > 0 && cmd_log[0] === 1'b1 && rx_log[0] === 8'h3C,
            "R6 restart command byte", rx_log[0], 8'h3C);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule